// File: doc/BRIEF.md
# Punctured Rate-1/2 Convolutional Encoder with Two-Bit Symbol Output

This block takes one data bit per accepted input and runs it through a rate-1/2 convolutional encoder with constraint length `K` and two generator polynomials. A puncture pattern of period `PN` then removes some of the coded bits, leaving `M` kept bits per `PN` inputs. The kept bits are packed two at a time onto a 2-bit output bus. A block of `2*PN` accepted inputs therefore yields exactly `M` symbols. Because `M < 2*PN`, the output never needs more cycles than the input. The ready-for-data flag is tied high and the source is never stalled.

Output is block-buffered. When the last input of a block is accepted, the block collected before it is emitted as a burst of `M` consecutive symbols. After a clear, the first burst is therefore all zeros. Under continuous input, output-ready shows a fixed pattern of `M` cycles high followed by `2*PN-M` cycles low.

A first-data strobe re-anchors the puncture pattern on the current input. The ready-for-first-data flag shows when this can be done without breaking a block. If the strobe arrives in the middle of a block, the partial block is closed early and emitted later.

Top module: `punc_pair_enc`

## Requirements
- R1: The coded pair for an input is c0 = XOR of (G0 AND w) and c1 = XOR of (G1 AND w). In the window w, bit K-1 is the current input and bit K-1-j is the input accepted j acceptances earlier. History is zero after clear.
- R2: The puncture phase is the position within the block modulo PN, where position 0 is the first input of a block. An input at phase p keeps c0 when P0[p] is 1 and keeps c1 when P1[p] is 1. When both are kept, c0 comes before c1.
- R3: Kept bits are paired in order. Within each symbol, dataOut[0] carries the earlier bit and dataOut[1] the later bit. Each block of 2*PN accepted inputs produces exactly M symbols, where M is the total number of ones in P0 and P1.
- R4: In the cycle after the edge that accepts the last input of a block, output-ready rises and stays high for M clock-enabled cycles. During this burst it shows the symbols of the previous block, one per enabled cycle. The first burst after clear is all zeros.
- R5: With new-data and clock enable held high, output-ready is high for exactly M of every 2*PN cycles.
- R6: Ready-for-data is always 1.
- R7: Ready-for-first-data is 1 exactly when the next accepted input starts a block. It is 0 in the cycle after an accepted input that carries first-data.
- R8: An accepted input carrying first-data takes block position 0. When it arrives at a block start, this is the same as an ordinary block start.
- R9: If first-data is accepted in mid-block, the bits already collected form a zero-padded block. The block held before it is emitted at once, replacing any burst still in progress. The current input starts a new block.
- R10: An input with new-data low is ignored. It changes neither the encoder history nor the block position.
- R11: While clock enable is low, no input is accepted and every output holds its value.
- R12: Synchronous clear empties all storage. After clear, output-ready is 0, the data bus is 0 and ready-for-first-data is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sclr | input | 1 | Synchronous clear, overrides clock enable |
| ce | input | 1 | Clock enable |
| nd | input | 1 | New data: din is valid |
| fd | input | 1 | First data: current input starts a block |
| din | input | 1 | Data bit to encode |
| dataOut | output | 2 | Output symbol, earlier kept bit in bit 0 |
| rdy | output | 1 | dataOut holds a valid symbol |
| rfd | output | 1 | Ready for data, always high |
| rffd | output | 1 | A block boundary is next, first-data is seamless |

## Verification
The bench builds the block with K=7, generators 1111001 and 1011011, PN=3 and masks 101 and 011. This gives M=4 and bursts of four symbols separated by two idle cycles. These values keep a block at six inputs, so all 64 bit patterns of a block can be swept. They also cover both single-keep phases and the double-keep phase, so the pair packing is checked across input boundaries. Mid-block first-data lands at every block position, which covers both burst truncation and zero padding.

// File: rtl/penc_pkg.sv
`timescale 1ns/1ps
package penc_pkg;

  // strobes from the control to the datapath, valid in the current cycle
  typedef struct packed {
    logic accept;    // input taken at the coming edge
    logic forced;    // first-data in mid-block: close block early
    logic lastIn;    // this input completes a block
    logic boundary;  // load output shifter and restart the burst
    logic advance;   // shift out one symbol
  } strobes_t;

  function automatic int onesCount(input logic [31:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/penc_ctrl.sv
`timescale 1ns/1ps
module penc_ctrl
  import penc_pkg::*;
#(
  parameter int PN = 3,
  parameter int M  = 4
) (
  input  logic                    clk,
  input  logic                    sclr,
  input  logic                    ce,
  input  logic                    nd,
  input  logic                    fd,
  output strobes_t                stb,
  output logic [$clog2(PN)-1:0]   phase,
  output logic                    rdy,
  output logic                    rffd
);
  localparam int BLK  = 2 * PN;
  localparam int POSW = $clog2(BLK);
  localparam int PW   = $clog2(PN);
  localparam int IW   = $clog2(M);

  logic [POSW-1:0] pos, effPos, phaseWide;
  logic            active;
  logic [IW-1:0]   idx;
  logic            restart;

  always_comb begin
    stb.accept   = ce & nd;
    restart      = stb.accept & fd;
    effPos       = restart ? '0 : pos;
    stb.lastIn   = stb.accept && (effPos == POSW'(BLK - 1));
    stb.forced   = restart && (pos != '0);
    stb.boundary = stb.lastIn | stb.forced;
    stb.advance  = ce & active;
    phaseWide    = (effPos >= POSW'(PN)) ? effPos - POSW'(PN) : effPos;
    phase        = PW'(phaseWide);
  end

  always_ff @(posedge clk) begin
    if (sclr) begin
      pos    <= '0;
      active <= 1'b0;
      idx    <= '0;
    end else if (ce) begin
      if (stb.accept) pos <= stb.lastIn ? '0 : effPos + POSW'(1);
      if (stb.boundary) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (active) begin
        if (idx == IW'(M - 1)) active <= 1'b0;
        idx <= idx + IW'(1);
      end
    end
  end

  assign rdy  = active;
  assign rffd = (pos == '0);

endmodule

// File: rtl/penc_dp.sv
`timescale 1ns/1ps
module penc_dp
  import penc_pkg::*;
#(
  parameter int            K  = 7,
  parameter logic [K-1:0]  G0 = 7'b1111001,
  parameter logic [K-1:0]  G1 = 7'b1011011,
  parameter int            PN = 3,
  parameter logic [PN-1:0] P0 = 3'b101,
  parameter logic [PN-1:0] P1 = 3'b011,
  parameter int            M  = 4
) (
  input  logic                  clk,
  input  logic                  sclr,
  input  logic                  ce,
  input  logic                  din,
  input  strobes_t              stb,
  input  logic [$clog2(PN)-1:0] phase,
  output logic [1:0]            dataOut
);
  localparam int KEPT = 2 * M;
  localparam int CW   = $clog2(KEPT + 1);
  localparam logic [1:0][K-1:0] GENS = {G1, G0};

  logic [K-2:0]   state;
  logic [K-1:0]   window;
  logic [1:0]     coded;
  logic           keep0, keep1;
  logic [1:0]     ins;
  logic [CW-1:0]  nk, kcnt, baseCnt;
  logic [KEPT-1:0] collect, hold, outReg, baseVec, merged;

  assign window = {din, state};

  for (genvar g = 0; g < 2; g++) begin : gParity
    assign coded[g] = ^(window & GENS[g]);
  end

  always_comb begin
    keep0 = P0[phase];
    keep1 = P1[phase];
    nk    = CW'(keep0) + CW'(keep1);
    if (keep0 && keep1) ins = coded;
    else if (keep0)     ins = {1'b0, coded[0]};
    else if (keep1)     ins = {1'b0, coded[1]};
    else                ins = 2'b00;
    baseVec = stb.forced ? '0 : collect;
    baseCnt = stb.forced ? '0 : kcnt;
    merged  = baseVec | (KEPT'(ins) << baseCnt);
  end

  always_ff @(posedge clk) begin
    if (sclr) begin
      state   <= '0;
      collect <= '0;
      kcnt    <= '0;
      hold    <= '0;
      outReg  <= '0;
    end else if (ce) begin
      if (stb.accept) begin
        state <= window[K-1:1];
        if (stb.lastIn) begin
          hold    <= merged;
          collect <= '0;
          kcnt    <= '0;
        end else begin
          collect <= merged;
          kcnt    <= baseCnt + nk;
          if (stb.forced) hold <= collect;
        end
      end
      if (stb.boundary)    outReg <= hold;
      else if (stb.advance) outReg <= outReg >> 2;
    end
  end

  assign dataOut = outReg[1:0];

endmodule

// File: rtl/punc_pair_enc.sv
`timescale 1ns/1ps
module punc_pair_enc
  import penc_pkg::*;
#(
  parameter int            K  = 7,
  parameter logic [K-1:0]  G0 = 7'b1111001,
  parameter logic [K-1:0]  G1 = 7'b1011011,
  parameter int            PN = 3,
  parameter logic [PN-1:0] P0 = 3'b101,
  parameter logic [PN-1:0] P1 = 3'b011
) (
  input  logic       clk,
  input  logic       sclr,
  input  logic       ce,
  input  logic       nd,
  input  logic       fd,
  input  logic       din,
  output logic [1:0] dataOut,
  output logic       rdy,
  output logic       rfd,
  output logic       rffd
);
  localparam int M = onesCount(32'(P0)) + onesCount(32'(P1));

  strobes_t                stb;
  logic [$clog2(PN)-1:0]   phase;

  penc_ctrl #(.PN(PN), .M(M)) uCtrl (
    .clk(clk), .sclr(sclr), .ce(ce), .nd(nd), .fd(fd),
    .stb(stb), .phase(phase), .rdy(rdy), .rffd(rffd)
  );

  penc_dp #(.K(K), .G0(G0), .G1(G1), .PN(PN), .P0(P0), .P1(P1), .M(M)) uDp (
    .clk(clk), .sclr(sclr), .ce(ce), .din(din),
    .stb(stb), .phase(phase), .dataOut(dataOut)
  );

  assign rfd = 1'b1;

endmodule

// File: rtl/penc_chk.sv
`timescale 1ns/1ps
module penc_chk (
  input logic       clk,
  input logic       sclr,
  input logic       ce,
  input logic       nd,
  input logic       fd,
  input logic [1:0] dataOut,
  input logic       rdy,
  input logic       rfd,
  input logic       rffd
);
  AST_RFD_ALWAYS: assert property (@(posedge clk) disable iff (sclr)
    rfd == 1'b1); // R6

  AST_FROZEN_OUTPUTS: assert property (@(posedge clk) disable iff (sclr)
    !ce |=> ($stable(dataOut) && $stable(rdy) && $stable(rffd))); // R11

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (sclr)
    $fell(sclr) |-> (!rdy && rffd && dataOut == 2'b00)); // R12

  AST_FD_DROPS_RFFD: assert property (@(posedge clk) disable iff (sclr)
    (ce && nd && fd) |=> !rffd); // R7

  AST_BURST_NEEDS_INPUT: assert property (@(posedge clk) disable iff (sclr)
    $rose(rdy) |-> $past(ce && nd)); // R4

endmodule

bind punc_pair_enc penc_chk uChk (
  .clk(clk), .sclr(sclr), .ce(ce), .nd(nd), .fd(fd),
  .dataOut(dataOut), .rdy(rdy), .rfd(rfd), .rffd(rffd)
);

// File: tb/sim_punc_pair_enc.sv
`timescale 1ns/1ps
module sim_punc_pair_enc;
  localparam int            K   = 7;
  localparam logic [K-1:0]  G0  = 7'b1111001;
  localparam logic [K-1:0]  G1  = 7'b1011011;
  localparam int            PN  = 3;
  localparam logic [PN-1:0] P0  = 3'b101;
  localparam logic [PN-1:0] P1  = 3'b011;
  localparam int            M   = 4;
  localparam int            BLK = 2 * PN;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic sclr = 1'b1, ce = 1'b0, nd = 1'b0, fd = 1'b0, din = 1'b0;
  logic [1:0] dataOut;
  logic rdy, rfd, rffd;

  punc_pair_enc #(.K(K), .G0(G0), .G1(G1), .PN(PN), .P0(P0), .P1(P1)) u0 (
    .clk(clk), .sclr(sclr), .ce(ce), .nd(nd), .fd(fd), .din(din),
    .dataOut(dataOut), .rdy(rdy), .rfd(rfd), .rffd(rffd)
  );

  int checks = 0, errors = 0;
  string curReq = "R12";
  bit done = 1'b0;

  // reference model state
  int          mPos = 0, mCnt = 0;
  logic [63:0] mCol = '0, mHold = '0;
  logic [15:0] mHist = '0;
  logic [1:0]  q [8];
  int          qRd = 0, qNum = 0;
  logic [15:0] lf = 16'hACE1;
  bit          lastRdy;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit lfBit();
    bit b;
    b  = lf[0];
    lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    return b;
  endfunction

  task automatic modelReset();
    mPos = 0; mCnt = 0; mCol = '0; mHold = '0; mHist = '0; qRd = 0; qNum = 0;
  endtask

  task automatic pushBlock(input logic [63:0] h);
    qRd = 0; qNum = M;
    for (int j = 0; j < M; j++) q[j] = {h[2*j+1], h[2*j]};
  endtask

  task automatic modelAccept(input bit f, input bit d);
    int eff, ph, bc;
    bit forced, last, c0, c1;
    logic [63:0] base, oldHold;
    eff    = f ? 0 : mPos;
    forced = f && (mPos != 0);
    last   = (eff == BLK - 1);
    ph     = eff % PN;
    c0 = d & G0[K-1];
    c1 = d & G1[K-1];
    for (int j = 1; j < K; j++) begin
      c0 ^= mHist[j-1] & G0[K-1-j];
      c1 ^= mHist[j-1] & G1[K-1-j];
    end
    mHist = {mHist[14:0], d};
    base = forced ? '0 : mCol;
    bc   = forced ? 0 : mCnt;
    if (P0[ph]) begin base[bc] = c0; bc++; end
    if (P1[ph]) begin base[bc] = c1; bc++; end
    if (forced) begin
      oldHold = mHold;
      mHold = mCol; mCol = base; mCnt = bc;
      pushBlock(oldHold);
    end else if (last) begin
      pushBlock(mHold);
      mHold = base; mCol = '0; mCnt = 0;
    end else begin
      mCol = base; mCnt = bc;
    end
    mPos = last ? 0 : eff + 1;
  endtask

  task automatic step(input bit s, input bit c, input bit n, input bit f, input bit d);
    @(negedge clk);
    chk(rfd === 1'b1, "R6", "rfd", int'(rfd), 1);
    chk(rffd === (mPos == 0), "R7", "rffd", int'(rffd), int'(mPos == 0));
    chk(rdy === (qNum > 0), curReq, "rdy", int'(rdy), int'(qNum > 0));
    lastRdy = rdy;
    if (rdy && c && !s && qNum > 0) begin
      chk(dataOut === q[qRd], curReq, "symbol", int'(dataOut), int'(q[qRd]));
      qRd++; qNum--;
    end
    sclr = s; ce = c; nd = n; fd = f; din = d;
    if (s) modelReset();
    else if (c && n) modelAccept(f, d);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    @(negedge clk);
    // R12: state right after clear
    chk(rdy === 1'b0 && dataOut === 2'b00 && rffd === 1'b1, "R12", "reset outputs",
        int'({rdy, dataOut, rffd}), 1);

    // R4: first burst after clear is zeros, second carries the first block
    curReq = "R4";
    for (int i = 0; i < 24; i++) step(0, 1, 1, 0, 1'b1);

    // R1: impulse response through the generators
    curReq = "R1";
    step(1, 1, 0, 0, 0);
    step(0, 1, 1, 0, 1);
    for (int i = 0; i < 29; i++) step(0, 1, 1, 0, 0);

    // R2: exhaustive sweep of every 6-bit block pattern
    curReq = "R2";
    for (int v = 0; v < 64; v++)
      for (int b = 0; b < BLK; b++) step(0, 1, 1, 0, v[b]);

    // R3: pseudo-random continuous stream
    curReq = "R3";
    for (int i = 0; i < 240; i++) step(0, 1, 1, 0, lfBit());

    // R5: burst duty under continuous input
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < BLK; i++) begin
        step(0, 1, 1, 0, lfBit());
        hi += int'(lastRdy);
      end
      chk(hi == M, "R5", "rdy cycles per block", hi, M);
    end

    // R10: gaps in new-data
    curReq = "R10";
    for (int i = 0; i < 200; i++) step(0, 1, lfBit() | lfBit(), 0, lfBit());

    // R11: clock enable held low at random
    curReq = "R11";
    for (int i = 0; i < 200; i++) step(0, lfBit() | lfBit(), 1, 0, lfBit());

    // R8: first-data on block starts
    curReq = "R8";
    for (int r = 0; r < 6; r++) begin
      while (mPos != 0) step(0, 1, 1, 0, lfBit());
      step(0, 1, 1, 1, lfBit());
      for (int i = 0; i < 13; i++) step(0, 1, 1, 0, lfBit());
    end

    // R9: first-data at every mid-block position
    curReq = "R9";
    for (int p = 1; p < BLK; p++) begin
      while (mPos != p) step(0, 1, 1, 0, lfBit());
      step(0, 1, 1, 1, lfBit());
      for (int i = 0; i < 3 + p; i++) step(0, 1, 1, 0, lfBit());
    end
    for (int i = 0; i < 24; i++) step(0, 1, 1, 0, lfBit());

    // R12: clear in the middle of a burst
    curReq = "R12";
    while (!(qNum > 1)) step(0, 1, 1, 0, lfBit());
    step(1, 1, 1, 0, 1);
    step(0, 0, 0, 0, 0);
    chk(rdy === 1'b0 && dataOut === 2'b00 && rffd === 1'b1, "R12", "mid-run clear",
        int'({rdy, dataOut, rffd}), 1);
    for (int i = 0; i < 30; i++) step(0, 1, 1, 0, lfBit());

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule